// File: doc/BRIEF.md
# Display Sync Waveform Generator

This block produces the periodic control waveforms a raster display needs, such as line sync, frame sync and data-valid strobes, together with a base pixel clock. All of it runs from one display clock. A line counter and a frame counter are chained. The line counter wraps at a programmable number of clocks. The frame counter steps once per line wrap and wraps at a programmable number of lines. Their wrap points are the start events that the outputs are timed from.

Each general-purpose output chooses either the line event or the frame event as its reference. It is high during a window bounded by a rise offset and a fall offset. Both offsets are counted from that reference in half-clock units. An edge can therefore fall on the rising or on the falling edge of the display clock. The pixel clock output uses the same window logic, timed against its own divider.

All configuration is static. It is meant to be changed only while reset is held.

Top module: `disp_sync_wavegen`

## Requirements
- R1: While `rst_n` is low, every output is low. After `rst_n` rises, the third rising clock edge is the first one that advances the counters. Call that edge E0 and the following edges E1, E2, and so on.
- R2: A line-referenced output treats the interval that starts at rising edge Ej as cycle position (j+1) mod L, where L is `line_period`. A value of 0 is treated as 1.
- R3: A frame-referenced output uses position (j+1) mod (L*F), where F is `frame_period`, again with 0 treated as 1. The frame count advances only on a line wrap.
- R4: Bit k of `pin_sel` selects the reference of output k. A value of 0 selects the line event and 1 selects the frame event.
- R5: Let p be the position. Take the half-clock index t = 2p while the clock is high, and t = 2p+1 while it is low. An output is high exactly when UP <= t < DOWN. An offset is coded as (whole clocks << 1) | half-bit.
- R6: An odd UP or DOWN offset makes the matching edge appear at a falling clock edge.
- R7: If UP >= DOWN, the output stays low for the whole period.
- R8: `pix_clk_o` follows the rule of R5 with position (j+1) mod D, where D is `pix_period` and 0 is treated as 1. Its offsets are `pix_up` and `pix_down`.
- R9: Pulling `rst_n` low in the middle of a clock phase drives every output low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_period | input | LW (12) | Clocks per line |
| frame_period | input | FW (10) | Lines per frame |
| pix_period | input | DW (8) | Clocks per pixel clock period |
| pix_up | input | DW+1 | Pixel clock rise offset, half-clock units |
| pix_down | input | DW+1 | Pixel clock fall offset, half-clock units |
| pin_up | input | NPIN x (PW+1) | Rise offset of each output, half-clock units |
| pin_down | input | NPIN x (PW+1) | Fall offset of each output, half-clock units |
| pin_sel | input | NPIN | Reference per output: 0 line, 1 frame |
| pix_clk_o | output | 1 | Base pixel clock |
| pin_o | output | NPIN | General-purpose sync outputs |

## Verification
The hardest case to reach is an edge that sits on a falling clock edge right at a period wrap. An example is a window that opens at an odd offset on a line of length one, or a frame-referenced output whose window crosses several line wraps. The vector table covers degenerate periods (0 and 1), odd offsets, windows longer than the period and reversed offsets. The bench samples every output once in each clock phase across at least two full frames. A directed test asserts reset while the clock is high and all outputs are known to be high. This shows that the outputs drop without waiting for an edge.

// File: rtl/dsg_pkg.sv
package dsg_pkg;
  localparam int DSG_NPIN = 7;
  localparam int DSG_LW   = 12;
  localparam int DSG_FW   = 10;
  localparam int DSG_DW   = 8;
  localparam int DSG_PW   = 16;

  typedef enum logic {
    REF_LINE  = 1'b0,
    REF_FRAME = 1'b1
  } ref_src_e;
endpackage

// File: rtl/dsg_timebase.sv
module dsg_timebase #(
  parameter int LW = 12,
  parameter int FW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] line_period,
  input  logic [FW-1:0] frame_period,
  input  logic [DW-1:0] pix_period,
  output logic          line_evt_nxt,
  output logic          frame_evt_nxt,
  output logic          pix_evt_nxt
);
  logic [LW-1:0] lc_q, lc_d;
  logic [FW-1:0] fc_q, fc_d;
  logic [DW-1:0] dc_q, dc_d;
  logic          line_last, frame_last, pix_last, fc_en;

  // next-state logic
  always_comb begin
    line_last  = (line_period <= LW'(1)) || (lc_q >= line_period - LW'(1));
    frame_last = (frame_period <= FW'(1)) || (fc_q >= frame_period - FW'(1));
    pix_last   = (pix_period <= DW'(1)) || (dc_q >= pix_period - DW'(1));
    lc_d       = line_last ? '0 : lc_q + LW'(1);
    fc_en      = line_last;
    fc_d       = frame_last ? '0 : fc_q + FW'(1);
    dc_d       = pix_last ? '0 : dc_q + DW'(1);
  end

  assign line_evt_nxt  = line_last;
  assign frame_evt_nxt = line_last && frame_last;
  assign pix_evt_nxt   = pix_last;

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_q <= '0;
      fc_q <= '0;
      dc_q <= '0;
    end else begin
      lc_q <= lc_d;
      if (fc_en) fc_q <= fc_d;
      dc_q <= dc_d;
    end
  end

  // R2
  line_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(line_period) && (line_period > LW'(1))) |-> (lc_q < line_period));

  // R3
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fc_q) |-> (lc_q == '0));

  // R8
  pix_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pix_period) && (pix_period > DW'(1))) |-> (dc_q < pix_period));
endmodule

// File: rtl/dsg_edge_gen.sv
module dsg_edge_gen #(
  parameter int CW = 16,
  localparam int OW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_nxt,
  input  logic [OW-1:0] up,
  input  logic [OW-1:0] down,
  output logic          wave
);
  logic [CW-1:0] pc_q, pc_d;
  logic [OW-1:0] t_even, t_odd;
  logic          want_even, want_odd;
  logic          p_q, p_d, n_q, n_d;

  // next-state logic: position counter and window compare per half-cycle
  always_comb begin
    if (start_nxt)   pc_d = '0;
    else if (&pc_q)  pc_d = pc_q;
    else             pc_d = pc_q + CW'(1);
    t_even    = {pc_d, 1'b0};
    t_odd     = {pc_q, 1'b1};
    want_even = (t_even >= up) && (t_even < down);
    want_odd  = (t_odd >= up) && (t_odd < down);
    p_d       = want_even ^ n_q;
    n_d       = want_odd ^ p_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      p_q  <= 1'b0;
    end else begin
      pc_q <= pc_d;
      p_q  <= p_d;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) n_q <= 1'b0;
    else        n_q <= n_d;
  end

  // only one of the two registers changes at each edge, so the xor never glitches
  assign wave = p_q ^ n_q;

  // R7
  flat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(up) && $stable(down) && (up >= down)) |-> !wave);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_nxt && !(&pc_q)) |=> (pc_q == $past(pc_q) + CW'(1)));
endmodule

// File: rtl/disp_sync_wavegen.sv
module disp_sync_wavegen
  import dsg_pkg::*;
#(
  parameter int NPIN = DSG_NPIN,
  parameter int LW   = DSG_LW,
  parameter int FW   = DSG_FW,
  parameter int DW   = DSG_DW,
  parameter int PW   = DSG_PW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LW-1:0]            line_period,
  input  logic [FW-1:0]            frame_period,
  input  logic [DW-1:0]            pix_period,
  input  logic [DW:0]              pix_up,
  input  logic [DW:0]              pix_down,
  input  logic [NPIN-1:0][PW:0]    pin_up,
  input  logic [NPIN-1:0][PW:0]    pin_down,
  input  logic [NPIN-1:0]          pin_sel,
  output logic                     pix_clk_o,
  output logic [NPIN-1:0]          pin_o
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       line_evt_nxt, frame_evt_nxt, pix_evt_nxt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  dsg_timebase #(.LW(LW), .FW(FW), .DW(DW)) u_tb (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .line_period   (line_period),
    .frame_period  (frame_period),
    .pix_period    (pix_period),
    .line_evt_nxt  (line_evt_nxt),
    .frame_evt_nxt (frame_evt_nxt),
    .pix_evt_nxt   (pix_evt_nxt)
  );

  dsg_edge_gen #(.CW(DW)) u_pix (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_nxt (pix_evt_nxt),
    .up        (pix_up),
    .down      (pix_down),
    .wave      (pix_clk_o)
  );

  for (genvar k = 0; k < NPIN; k++) begin : g_pin
    logic start_k;
    assign start_k = (ref_src_e'(pin_sel[k]) == REF_FRAME) ? frame_evt_nxt : line_evt_nxt;
    dsg_edge_gen #(.CW(PW)) u_edge (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .start_nxt (start_k),
      .up        (pin_up[k]),
      .down      (pin_down[k]),
      .wave      (pin_o[k])
    );
  end
endmodule

// File: tb/tb_disp_sync_wavegen.sv
module tb_disp_sync_wavegen;
  localparam int NPIN = 7;
  localparam int LW   = 12;
  localparam int FW   = 10;
  localparam int DW   = 8;
  localparam int PW   = 16;

  typedef struct packed {
    int l; int f; int d; int pu; int pd; int bu; int bd; int sel;
  } vec_t;

  // L, F, D, pix up, pix down, pin up base, pin down base, select mask
  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{10, 3, 4, 0, 4,  2,  7, 'h55},
    '{ 7, 2, 3, 1, 4,  3,  6, 'h00},
    '{ 1, 4, 1, 0, 1,  0,  1, 'h7F},
    '{ 0, 0, 0, 1, 2,  0,  2, 'h0F},
    '{12, 2, 5, 6, 3,  9,  9, 'h33},
    '{16, 3, 6, 0, 12, 20, 40, 'h7E}
  };

  logic                  clk;
  logic                  rst_n;
  logic [LW-1:0]         line_period;
  logic [FW-1:0]         frame_period;
  logic [DW-1:0]         pix_period;
  logic [DW:0]           pix_up, pix_down;
  logic [NPIN-1:0][PW:0] pin_up, pin_down;
  logic [NPIN-1:0]       pin_sel;
  logic                  pix_clk_o;
  logic [NPIN-1:0]       pin_o;

  int n_chk;
  int n_fail;

  disp_sync_wavegen dut (
    .clk(clk), .rst_n(rst_n), .line_period(line_period), .frame_period(frame_period),
    .pix_period(pix_period), .pix_up(pix_up), .pix_down(pix_down),
    .pin_up(pin_up), .pin_down(pin_down), .pin_sel(pin_sel),
    .pix_clk_o(pix_clk_o), .pin_o(pin_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  function automatic logic in_win(input int t, input int up, input int dn);
    return (t >= up) && (t < dn);
  endfunction

  function automatic string pin_tag(input int up, input int dn, input bit fr);
    if (up >= dn) return "R7";
    if (((up | dn) & 1) != 0) return fr ? "R6 R3 R4" : "R6 R2 R4";
    return fr ? "R5 R3 R4" : "R5 R2 R4";
  endfunction

  task automatic load_cfg(input vec_t v);
    line_period  = LW'(v.l);
    frame_period = FW'(v.f);
    pix_period   = DW'(v.d);
    pix_up       = (DW+1)'(v.pu);
    pix_down     = (DW+1)'(v.pd);
    pin_sel      = NPIN'(v.sel);
    for (int k = 0; k < NPIN; k++) begin
      pin_up[k]   = (PW+1)'(v.bu + k);
      pin_down[k] = (PW+1)'(v.bd + 3 * k);
    end
  endtask

  // hold reset, load config, release at a falling edge, skip two sync edges
  task automatic restart(input vec_t v);
    rst_n = 1'b0;
    @(negedge clk);
    load_cfg(v);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
  endtask

  task automatic check_phase(input vec_t v, input int j, input int ph);
    int l1, f1, d1, pos, t, up, dn;
    bit fr;
    l1 = (v.l < 1) ? 1 : v.l;
    f1 = (v.f < 1) ? 1 : v.f;
    d1 = (v.d < 1) ? 1 : v.d;
    pos = (j + 1) % d1;
    t = 2 * pos + ph;
    // R8 pixel clock window on its own divider
    chk("R8", pix_clk_o, in_win(t, v.pu, v.pd));
    for (int k = 0; k < NPIN; k++) begin
      fr  = v.sel[k];
      pos = fr ? (j + 1) % (l1 * f1) : (j + 1) % l1;
      t   = 2 * pos + ph;
      up  = v.bu + k;
      dn  = v.bd + 3 * k;
      chk(pin_tag(up, dn, fr), pin_o[k], in_win(t, up, dn));
    end
  endtask

  initial begin
    vec_t hi;
    n_chk  = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    hi = '{8, 2, 2, 0, 4, 0, 200, 'h00};
    load_cfg(hi);

    // R1: outputs low under reset even with always-on windows configured
    repeat (3) @(posedge clk);
    #5;
    chk("R1", pix_clk_o, 1'b0);
    for (int k = 0; k < NPIN; k++) chk("R1", pin_o[k], 1'b0);

    // table of vectors, every output sampled in both clock phases
    for (int vi = 0; vi < NVEC; vi++) begin
      int l1, f1, ncyc;
      restart(VECS[vi]);
      l1 = (VECS[vi].l < 1) ? 1 : VECS[vi].l;
      f1 = (VECS[vi].f < 1) ? 1 : VECS[vi].f;
      ncyc = 2 * l1 * f1 + 6;
      for (int j = 0; j < ncyc; j++) begin
        @(posedge clk);
        #5;
        check_phase(VECS[vi], j, 0);
        @(negedge clk);
        #5;
        check_phase(VECS[vi], j, 1);
      end
    end

    // R9: reset asserted mid high phase drops outputs before the next edge
    restart(hi);
    repeat (5) @(posedge clk);
    #2;
    chk("R5", pix_clk_o, 1'b1);
    for (int k = 0; k < NPIN; k++) chk("R5", pin_o[k], 1'b1);
    #1;
    rst_n = 1'b0;
    #1;
    chk("R9", pix_clk_o, 1'b0);
    for (int k = 0; k < NPIN; k++) chk("R9", pin_o[k], 1'b0);
    @(negedge clk);
    #5;
    chk("R1", pix_clk_o, 1'b0);
    chk("R1", pin_o[0], 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule